// File: doc/BRIEF.md
# Supply-Fail Monitor and Reset Sequencer

This clocked controller watches three digitized supply comparators, ordered from the highest trip level to the lowest. The first reports that the supply has dropped under a warning level. The second reports that it is under the minimum level needed to run. The third reports that it is under the level where the chip switches to its backup cell. Each level has its own action. The warning level only raises an interrupt request, and the processor keeps running. The minimum level holds the processor in reset and pulls a shared reset line low. The backup level also drops an active-low backup flag. When the supply recovers, reset stays asserted for a fixed power-on delay and is then released.

The reset line is open-drain with an external pull-up, so several devices can share it. The block senses the line whenever it is not driving it. When another device pulls the line low, this block enters its own power-on delay. While the delay runs, the block drives the line low itself, so all devices on the line leave reset together. Every comparator input and the sensed line pass through a two-flop synchronizer and a persistence filter before they act.

Top module: `supply_guard`

## Requirements
- R1: A change on any comparator input takes effect only after the synchronized value has differed from the accepted value for FILT_CYCLES consecutive clocks (default 4). The state output reacts FILT_CYCLES+3 clocks after the input changes. A pulse shorter than FILT_CYCLES clocks has no effect.
- R2: When only the warning comparator is active, the block enters WARN (state code 1). In WARN, cpu_rst_o is 0, the reset line is released (rst_line_oe_o = 0) and bkp_n_o is 1, so execution continues.
- R3: Each entry into WARN raises irq_o in the same clock, but only if pfw_en_i is 1. While irq_o is 1, irq_vec_o reads 8'h2B; otherwise it reads 8'h00. If pfw_en_i is 0, that crossing produces no request.
- R4: A request stays pending, even after the supply leaves WARN, until irq_ack_i is sampled high (cleared one clock later) or a reset state is entered. After an acknowledge, a new request is raised only on a later entry into WARN.
- R5: When the minimum-level comparator is active, the block enters RESET (code 2), with cpu_rst_o = 1 and rst_line_oe_o = 1. This takes priority over the warning level.
- R6: When the backup-level comparator is active, the block enters BACKUP (code 3), with bkp_n_o = 0 and reset still held. This has the highest priority.
- R7: Leaving BACKUP while the minimum level is still active goes to RESET. Rising above the minimum level from RESET or from BACKUP goes to POR_DELAY (code 4), and reset stays asserted there.
- R8: POR_DELAY holds reset for exactly POR_CYCLES clocks (default 21504), counted from the clock that entered it. At the end, the block goes to WARN if the warning comparator is still active, and to NORMAL (code 0) otherwise. The asynchronous reset also starts in POR_DELAY.
- R9: If the minimum level drops again during POR_DELAY, the block returns to RESET. The next recovery restarts the full delay.
- R10: While the block is not driving the reset line, a low level sensed there for FILT_CYCLES synchronized clocks sends NORMAL or WARN to POR_DELAY, FILT_CYCLES+2 clocks after the line falls. For two clocks after the block stops driving, the line is not sensed, so the block's own release does not retrigger it.
- R11: state_o encodes NORMAL=0, WARN=1, RESET=2, BACKUP=3, POR_DELAY=4, and no other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, starts in POR_DELAY |
| warn_low_i | input | 1 | Supply under warning level |
| min_low_i | input | 1 | Supply under minimum operating level |
| bkp_low_i | input | 1 | Supply under backup-switch level |
| pfw_en_i | input | 1 | Enables the warning interrupt |
| irq_ack_i | input | 1 | Acknowledges the pending warning request |
| rst_line_i | input | 1 | Sensed level of the shared reset line |
| rst_line_oe_o | output | 1 | Pulls the shared reset line low when 1 |
| cpu_rst_o | output | 1 | Processor reset |
| irq_o | output | 1 | Warning interrupt request |
| irq_vec_o | output | 8 | Interrupt vector while the request is pending |
| bkp_n_o | output | 1 | Low while running from the backup cell |
| state_o | output | 3 | Sequencer state code |

## Verification
Comparator changes reach state_o, the reset outputs and irq_o FILT_CYCLES+3 clocks after the input changes. A pull on the reset line takes effect after FILT_CYCLES+2 clocks. An acknowledge clears the request one clock after it is sampled, and the end of POR_DELAY comes POR_CYCLES clocks after its entry clock. The driver task stores each expected outcome together with the absolute clock in which it is due. It usually also stores the clock just before, to confirm that nothing changes early. The monitor compares the outputs on the falling edge of exactly those clocks.

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int          FILT_CYCLES = 4,
  parameter int          POR_CYCLES  = 21504,
  parameter logic [7:0]  IRQ_VECTOR  = 8'h2B
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       warn_low_i,
  input  logic       min_low_i,
  input  logic       bkp_low_i,
  input  logic       pfw_en_i,
  input  logic       irq_ack_i,
  input  logic       rst_line_i,
  output logic       rst_line_oe_o,
  output logic       cpu_rst_o,
  output logic       irq_o,
  output logic [7:0] irq_vec_o,
  output logic       bkp_n_o,
  output logic [2:0] state_o
);

  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam logic [FW-1:0] FILT_LAST = FW'(FILT_CYCLES - 1);
  localparam logic [PW-1:0] POR_LAST  = PW'(POR_CYCLES - 1);

  typedef enum logic [2:0] {
    S_NORMAL = 3'd0,
    S_WARN   = 3'd1,
    S_RESET  = 3'd2,
    S_BACKUP = 3'd3,
    S_POR    = 3'd4
  } state_t;

  state_t          state_q, state_d;
  logic [3:0]      sync1, sync2;
  logic [2:0]      flt;
  logic [FW-1:0]   fcnt [3];
  logic [FW-1:0]   xcnt;
  logic [1:0]      oe_hist;
  logic [PW-1:0]   por_cnt;
  logic            irq_q;
  logic            w_f, m_f, b_f, xmask, ext_det, rst_next;

  // two-flop synchronizer; bit 3 is "reset line seen low"
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {~rst_line_i, bkp_low_i, min_low_i, warn_low_i};
      sync2 <= sync1;
    end
  end

  // persistence filter per comparator
  for (genvar i = 0; i < 3; i++) begin : g_filt
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        flt[i]  <= 1'b0;
        fcnt[i] <= '0;
      end else if (sync2[i] == flt[i]) begin
        fcnt[i] <= '0;
      end else if (fcnt[i] == FILT_LAST) begin
        flt[i]  <= sync2[i];
        fcnt[i] <= '0;
      end else begin
        fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  assign w_f = flt[0];
  assign m_f = flt[1];
  assign b_f = flt[2];

  // external pull detection, blind while driving and two clocks after
  assign xmask   = rst_line_oe_o | (|oe_hist);
  assign ext_det = !xmask && sync2[3] && (xcnt == FILT_LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      oe_hist <= 2'b11;
      xcnt    <= '0;
    end else begin
      oe_hist <= {oe_hist[0], rst_line_oe_o};
      if (xmask || !sync2[3])   xcnt <= '0;
      else if (xcnt != FILT_LAST) xcnt <= xcnt + 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_NORMAL: if (ext_det) state_d = S_POR; else if (w_f) state_d = S_WARN;
      S_WARN:   if (ext_det) state_d = S_POR; else if (!w_f) state_d = S_NORMAL;
      S_RESET:  if (!m_f) state_d = S_POR;
      S_BACKUP: state_d = m_f ? S_RESET : S_POR;
      S_POR:    if (por_cnt == POR_LAST) state_d = w_f ? S_WARN : S_NORMAL;
      default:  state_d = S_NORMAL;
    endcase
    if (b_f)      state_d = S_BACKUP;
    else if (m_f) state_d = S_RESET;
  end

  assign rst_next = state_d inside {S_RESET, S_BACKUP, S_POR};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= S_POR;
      por_cnt <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      por_cnt <= (state_q == S_POR && state_d == S_POR) ? por_cnt + 1'b1 : '0;
      if (state_d == S_WARN && state_q != S_WARN && pfw_en_i) irq_q <= 1'b1;
      else if (irq_ack_i || rst_next)                          irq_q <= 1'b0;
    end
  end

  assign cpu_rst_o     = state_q inside {S_RESET, S_BACKUP, S_POR};
  assign rst_line_oe_o = cpu_rst_o;
  assign bkp_n_o       = (state_q != S_BACKUP);
  assign irq_o         = irq_q;
  assign irq_vec_o     = irq_q ? IRQ_VECTOR : 8'h00;
  assign state_o       = state_q;

  p_min_holds_rst_r5: assert property (@(posedge clk) disable iff (!arst_n)
    m_f |=> cpu_rst_o);

  p_backup_flag_r6: assert property (@(posedge clk) disable iff (!arst_n)
    b_f |=> !bkp_n_o);

  p_irq_source_r3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(irq_q) |-> (state_q == S_WARN && $past(pfw_en_i)));

  p_irq_pending_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (irq_q && !irq_ack_i && !m_f && !b_f && !ext_det) |=> irq_q);

  p_por_length_r8: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(cpu_rst_o) |-> ($past(state_q) == S_POR && $past(por_cnt) == POR_LAST));

  p_ext_pull_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (ext_det && !m_f && !b_f) |=> state_q == S_POR);

  p_state_code_r11: assert property (@(posedge clk) disable iff (!arst_n)
    state_o <= 3'd4);

endmodule

// File: tb/test_supply_guard.sv
module test_supply_guard;
  localparam int FILT = 4;
  localparam int POR  = 200;
  localparam int L    = FILT + 3;
  localparam int XL   = FILT + 2;
  localparam logic [2:0] NRM = 3'd0, WRN = 3'd1, RST = 3'd2, BKP = 3'd3, PRD = 3'd4;

  logic clk = 1'b0, arst_n = 1'b0;
  logic w = 1'b0, m = 1'b0, b = 1'b0, en = 1'b0, ack = 1'b0, ext_pull = 1'b0;
  logic rst_line, oe, cpu_rst, irq, bkp_n;
  logic [7:0] vec;
  logic [2:0] st;
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { int at; logic [2:0] st; logic irq; string tag; } exp_t;
  exp_t q[$];

  assign rst_line = (oe || ext_pull) ? 1'b0 : 1'b1;

  supply_guard #(.FILT_CYCLES(FILT), .POR_CYCLES(POR)) i_supply_guard (
    .clk(clk), .arst_n(arst_n), .warn_low_i(w), .min_low_i(m), .bkp_low_i(b),
    .pfw_en_i(en), .irq_ack_i(ack), .rst_line_i(rst_line),
    .rst_line_oe_o(oe), .cpu_rst_o(cpu_rst), .irq_o(irq), .irq_vec_o(vec),
    .bkp_n_o(bkp_n), .state_o(st));

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [14:0] model(logic [2:0] s, logic i);
    logic r;
    r = (s == RST) || (s == BKP) || (s == PRD);
    return {s, r, r, i, (s != BKP), (i ? 8'h2B : 8'h00)};
  endfunction

  task automatic chk(string tag, logic [14:0] act, logic [14:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      if (q[0].at < cyc) chk({q[0].tag, " (missed)"}, 15'h7fff, 15'h0);
      else chk(q[0].tag, {st, cpu_rst, oe, irq, bkp_n, vec}, model(q[0].st, q[0].irq));
      void'(q.pop_front());
    end
  end

  task automatic exp_in(int d, logic [2:0] s, logic i, string tag);
    q.push_back('{cyc + d, s, i, tag});
  endtask

  task automatic exp_abs(int at, logic [2:0] s, logic i, string tag);
    q.push_back('{at, s, i, tag});
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic pulse_ack(logic [2:0] s);
    @(negedge clk);
    ack = 1'b1;
    exp_in(1, s, 1'b0, "R4 ack clears");
    @(negedge clk);
    ack = 1'b0;
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    chk("R8 R11 reset state", {st, cpu_rst, oe, irq, bkp_n, vec}, model(PRD, 1'b0));
    arst_n = 1'b1;
    exp_in(POR - 1, PRD, 1'b0, "R8 still in delay");
    exp_in(POR, NRM, 1'b0, "R8 release after reset");
    drain();

    en = 1'b1;
    @(negedge clk); w = 1'b1;
    exp_in(L - 1, NRM, 1'b0, "R1 no early change");
    exp_in(L, WRN, 1'b1, "R2 R3 warning raises request");
    drain();
    pulse_ack(WRN);
    repeat (20) @(negedge clk);
    exp_in(1, WRN, 1'b0, "R4 no rearm inside warning");
    drain();

    @(negedge clk); w = 1'b0;
    exp_in(L, NRM, 1'b0, "R2 back to normal");
    drain();
    en = 1'b0;
    @(negedge clk); w = 1'b1;
    exp_in(L, WRN, 1'b0, "R3 disabled crossing silent");
    drain();
    @(negedge clk); w = 1'b0;
    exp_in(L, NRM, 1'b0, "R2 normal again");
    drain();
    en = 1'b1;
    @(negedge clk); w = 1'b1;
    exp_in(L, WRN, 1'b1, "R3 request on new crossing");
    drain();
    @(negedge clk); w = 1'b0;
    exp_in(L, NRM, 1'b1, "R4 stays pending out of warning");
    drain();
    pulse_ack(NRM);

    @(negedge clk); w = 1'b1;
    repeat (3) @(negedge clk);
    w = 1'b0;
    exp_in(12, NRM, 1'b0, "R1 short pulse ignored");
    drain();

    @(negedge clk); w = 1'b1; m = 1'b1;
    exp_in(L - 1, NRM, 1'b0, "R1 no early reset");
    exp_in(L, RST, 1'b0, "R5 minimum forces reset");
    drain();
    @(negedge clk); m = 1'b0;
    exp_in(L, PRD, 1'b0, "R7 recovery enters delay");
    exp_in(L + POR - 1, PRD, 1'b0, "R8 delay length");
    exp_in(L + POR, WRN, 1'b1, "R8 delay ends in warning");
    drain();
    pulse_ack(WRN);

    @(negedge clk); m = 1'b1; b = 1'b1;
    exp_in(L, BKP, 1'b0, "R6 backup entered");
    drain();
    @(negedge clk); b = 1'b0;
    exp_in(L, RST, 1'b0, "R7 backup to reset");
    drain();
    @(negedge clk); b = 1'b1;
    exp_in(L, BKP, 1'b0, "R6 backup again");
    drain();
    @(negedge clk); b = 1'b0; m = 1'b0; w = 1'b0;
    exp_in(L, PRD, 1'b0, "R7 backup to delay");
    exp_in(L + POR, NRM, 1'b0, "R8 delay ends in normal");
    drain();

    @(negedge clk); m = 1'b1;
    exp_in(L, RST, 1'b0, "R5 reset");
    drain();
    @(negedge clk); m = 1'b0;
    exp_in(L, PRD, 1'b0, "R7 delay");
    repeat (50) @(negedge clk);
    m = 1'b1;
    exp_in(L, RST, 1'b0, "R9 dip during delay");
    drain();
    @(negedge clk); m = 1'b0;
    exp_in(L + POR - 1, PRD, 1'b0, "R9 delay restarted");
    exp_in(L + POR, NRM, 1'b0, "R9 full delay then release");
    drain();

    @(negedge clk); ext_pull = 1'b1; t0 = cyc;
    exp_in(XL - 1, NRM, 1'b0, "R10 no early pull response");
    exp_in(XL, PRD, 1'b0, "R10 external pull enters delay");
    repeat (10) @(negedge clk);
    ext_pull = 1'b0;
    exp_abs(t0 + XL + POR, NRM, 1'b0, "R10 R8 released");
    exp_abs(t0 + XL + POR + 20, NRM, 1'b0, "R10 own release not retriggered");
    drain();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule